// File: doc/BRIEF.md
# Credit-Gated Virtual-Channel Network Interface

This block sits between a processing element and the local port of a network router. On the transmit side each virtual channel (VC) takes a byte stream from the processing element, with a marker on the last byte of every frame. It turns each byte into one flit, gives the flit a one-hot type (head, body or tail) and stamps it with the index of the channel that sent it. A flit may leave only while its channel holds a credit token. The tokens start at half the depth of the router's input buffer. They are replenished one at a time over a four-phase request/acknowledge handshake per channel, and that handshake may come from another clock domain. When several channels are eligible in the same cycle, a round-robin arbiter picks one flit for the single output port.

On the receive side, flits from the router are steered by their channel field into that channel's reassembly buffer, which holds up to one maximum-length frame. When the tail flit is stored, the frame is marked ready. The processing element then selects a channel and pops the frame out one byte at a time, and the buffer is freed after the last byte.

Top module: `noc_credit_ni`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `net_out_valid`, every bit of `cr_ack` and every bit of `rx_frame_rdy` are low.
- R2: Each channel starts with DOWN_DEPTH/2 tokens (default 1). Its token count never rises above that value. With no credit returned, a channel sends exactly that many flits and then stalls.
- R3: A channel is offered (`pe_tx_ready` high) and sends a flit only while its token count is non-zero. Each flit sent uses up one token. A channel with no tokens keeps `pe_tx_ready` low and sends nothing until a credit arrives.
- R4: Credit return is four-phase. A rising `cr_req[v]` adds one token to channel v and raises `cr_ack[v]`. A falling `cr_req[v]` lowers `cr_ack[v]`. Each change of `cr_ack` is visible at the third falling clock edge after the matching request change, counting from the falling edge at which the request was driven (two synchronizer flops, then one registered stage).
- R5: Every outgoing flit carries in `net_out_vc` the index of the channel that sent it.
- R6: Flit type is one-hot: bit 0 = head, bit 1 = body, bit 2 = tail. The first byte of a frame is a head (3'b001) and the last is a tail (3'b100). Bytes in between are body (3'b010). A one-byte frame is 3'b101. After a tail, the channel's next byte starts a new frame.
- R7: When more than one channel is eligible, grants rotate round-robin, starting after the channel granted last. After reset, channel 0 has first priority. At most one channel is granted per cycle.
- R8: A byte accepted at a rising edge (`pe_tx_valid` and `pe_tx_ready` both high) appears on the `net_out_*` ports from that edge onward. `net_out_valid` is high for exactly that cycle.
- R9: A received flit with `net_in_valid` high is written into the buffer of channel `net_in_vc`. That channel's `rx_frame_rdy` bit rises at the edge that stores a flit with the tail bit (bit 2) set.
- R10: With `rx_sel` = v and `rx_frame_rdy[v]` high, `rx_byte` shows the frame's bytes in arrival order. Each `rx_pop` advances one byte. `rx_last` is high on the final byte, and popping the final byte clears `rx_frame_rdy[v]`.
- R11: Flits for a channel whose frame is ready are discarded until that frame is read out. A head flit restarts assembly. A buffer holds FRAME_MAX (default 512) bytes. Bytes beyond that are dropped, and the tail still releases the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pe_tx_valid | input | NUM_VC | Per-channel byte valid from the processing element |
| pe_tx_byte | input | 8*NUM_VC | Per-channel transmit byte, channel v at bits [8v+7:8v] |
| pe_tx_last | input | NUM_VC | Per-channel marker for the last byte of a frame |
| pe_tx_ready | output | NUM_VC | Per-channel accept, at most one bit high |
| net_out_valid | output | 1 | Outgoing flit valid |
| net_out_data | output | 8 | Outgoing flit byte |
| net_out_type | output | 3 | Outgoing flit type, one-hot head/body/tail |
| net_out_vc | output | VCW | Channel index of the outgoing flit |
| cr_req | input | NUM_VC | Credit request per channel, may be asynchronous |
| cr_ack | output | NUM_VC | Credit acknowledge per channel |
| net_in_valid | input | 1 | Incoming flit valid |
| net_in_data | input | 8 | Incoming flit byte |
| net_in_type | input | 3 | Incoming flit type, one-hot head/body/tail |
| net_in_vc | input | VCW | Channel of the incoming flit |
| rx_frame_rdy | output | NUM_VC | Per-channel complete-frame flag |
| rx_sel | input | VCW | Channel selected for readout |
| rx_pop | input | 1 | Advance readout of the selected channel |
| rx_byte | output | 8 | Current byte of the selected channel's frame |
| rx_last | output | 1 | Current byte is the frame's final byte |

## Verification
The bench targets the token boundary. A channel must stall after its single initial token and resume only after a credit handshake. A design that miscounts would either emit a second flit without credit or hang forever. It checks the exact acknowledge latency on both handshake phases and tests two channels competing when both run out of tokens in the same cycle; a wrong rotation shows up as a repeated channel index. On the receive side it interleaves flits of two channels, sends a second frame into a channel that is already full, and sends a frame longer than the buffer. A design that mis-steers, overwrites or wraps would then return corrupted bytes or put `rx_last` on the wrong byte.

// File: rtl/noc_ni_pkg.sv
// Shared constants for the credit-gated network interface.
// Assumes one byte of payload per flit and a 3-bit one-hot flit type.
package noc_ni_pkg;

    localparam int BYTE_W = 8;
    localparam int FT_W   = 3;

    typedef logic [FT_W-1:0] ftype_t;

    localparam ftype_t FT_HEAD = 3'b001;
    localparam ftype_t FT_BODY = 3'b010;
    localparam ftype_t FT_TAIL = 3'b100;

    // Build the one-hot type of a flit from its position in the frame.
    function automatic ftype_t make_type(input logic first, input logic last);
        ftype_t t;
        t = '0;
        if (first) t = t | FT_HEAD;
        if (last)  t = t | FT_TAIL;
        if (!first && !last) t = FT_BODY;
        return t;
    endfunction

endpackage

// File: rtl/noc_ni_credit_port.sv
// Per-channel credit tracker.
// What it does: keeps the token count of one virtual channel and runs the
// receiving half of a four-phase credit handshake.
// Assumes: cr_req may be asynchronous, so it passes through two flops before
// use. The sender never returns more credits than flits it received.
module noc_ni_credit_port #(
    parameter int INIT_TOK = 1,
    parameter int TOKW     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cr_req,
    input  logic spend,
    output logic cr_ack,
    output logic has_token
);

    logic            sync_a, sync_b, sync_c;
    logic            req_rise, req_fall;
    logic [TOKW-1:0] tokens;

    // Bring the request into the clock domain and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
            sync_c <= 1'b0;
        end else begin
            sync_a <= cr_req;
            sync_b <= sync_a;
            sync_c <= sync_b;
        end
    end

    assign req_rise = sync_b & ~sync_c;
    assign req_fall = ~sync_b & sync_c;

    // Token count: add on a credit edge, remove on a sent flit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tokens <= TOKW'(INIT_TOK);
        end else begin
            case ({req_rise, spend})
                2'b10:   tokens <= tokens + 1'b1;
                2'b01:   tokens <= tokens - 1'b1;
                default: tokens <= tokens;
            endcase
        end
    end

    // Acknowledge follows the synchronized request level.
    always_ff @(posedge clk) begin
        if (!rst_n)        cr_ack <= 1'b0;
        else if (req_rise) cr_ack <= 1'b1;
        else if (req_fall) cr_ack <= 1'b0;
    end

    assign has_token = (tokens != '0);

    p_token_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tokens <= TOKW'(INIT_TOK));

    p_spend_needs_token_r3: assert property (@(posedge clk) disable iff (!rst_n)
        spend |-> tokens != '0);

    p_ack_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_rise |=> cr_ack);

    p_ack_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_fall |=> !cr_ack);

endmodule

// File: rtl/noc_ni_tx_sched.sv
// Transmit scheduler.
// What it does: chooses one eligible channel per cycle round-robin, marks
// frame boundaries as flit types and registers the outgoing flit.
// Assumes: a channel is eligible when it has a byte and a token. Its grant is
// also its ready back to the processing element.
module noc_ni_tx_sched
    import noc_ni_pkg::*;
#(
    parameter int NUM_VC = 2,
    parameter int VCW    = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_VC-1:0]        pe_valid,
    input  logic [NUM_VC-1:0]        pe_last,
    input  logic [NUM_VC*BYTE_W-1:0] pe_byte,
    input  logic [NUM_VC-1:0]        has_token,
    output logic [NUM_VC-1:0]        grant,
    output logic                     out_valid,
    output logic [BYTE_W-1:0]        out_data,
    output ftype_t                   out_type,
    output logic [VCW-1:0]           out_vc
);

    logic [NUM_VC-1:0] req;
    logic [NUM_VC-1:0] in_frame;
    logic [VCW-1:0]    last_q;
    logic [VCW-1:0]    gidx;
    logic              found;

    assign req = pe_valid & has_token;

    // Round-robin pick starting one past the last winner.
    always_comb begin
        int idx;
        grant = '0;
        found = 1'b0;
        gidx  = '0;
        for (int off = 1; off <= NUM_VC; off++) begin
            idx = (int'(last_q) + off) % NUM_VC;
            if (!found && req[idx]) begin
                found      = 1'b1;
                gidx       = VCW'(idx);
                grant[idx] = 1'b1;
            end
        end
    end

    // Remember the winner for the next rotation.
    always_ff @(posedge clk) begin
        if (!rst_n)     last_q <= VCW'(NUM_VC - 1);
        else if (found) last_q <= gidx;
    end

    // Track per channel whether a frame is under way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= '0;
        end else begin
            for (int v = 0; v < NUM_VC; v++) begin
                if (grant[v]) in_frame[v] <= ~pe_last[v];
            end
        end
    end

    // Register the chosen flit onto the router port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_type  <= '0;
            out_vc    <= '0;
        end else begin
            out_valid <= found;
            if (found) begin
                out_data <= pe_byte[int'(gidx)*BYTE_W +: BYTE_W];
                out_type <= make_type(~in_frame[gidx], pe_last[gidx]);
                out_vc   <= gidx;
            end
        end
    end

    p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_type_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_type == FT_HEAD || out_type == FT_BODY ||
                       out_type == FT_TAIL || out_type == (FT_HEAD | FT_TAIL)));

    p_no_grant_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> (grant == '0));

endmodule

// File: rtl/noc_ni_rx_lane.sv
// Receive reassembly lane for one virtual channel.
// What it does: stores flit bytes in order, releases the frame on the tail
// and streams it back out on pops.
// Assumes: write enable is already qualified by the channel field. The
// storage array has no reset, because its contents are don't-care until written.
module noc_ni_rx_lane
    import noc_ni_pkg::*;
#(
    parameter int FRAME_MAX = 512,
    parameter int CNTW      = 10,
    parameter int PTRW      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  ftype_t            wr_type,
    input  logic              rd_pop,
    output logic              frame_rdy,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              rd_last
);

    logic [BYTE_W-1:0] mem [FRAME_MAX];
    logic [CNTW-1:0]   cnt;
    logic [CNTW-1:0]   rdptr;
    logic [CNTW-1:0]   wslot;
    logic              accept, room, is_head, is_tail;

    assign is_head = wr_type[0];
    assign is_tail = wr_type[2];
    assign accept  = wr_en && !frame_rdy;
    assign wslot   = is_head ? '0 : cnt;
    assign room    = is_head || (cnt < CNTW'(FRAME_MAX));
    assign rd_byte = mem[rdptr[PTRW-1:0]];
    assign rd_last = frame_rdy && (rdptr == cnt - CNTW'(1));

    // Storage write for an accepted byte that fits.
    always_ff @(posedge clk) begin
        if (accept && room) mem[wslot[PTRW-1:0]] <= wr_byte;
    end

    // Fill count, read pointer and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            rdptr     <= '0;
            frame_rdy <= 1'b0;
        end else if (frame_rdy) begin
            if (rd_pop) begin
                if (rd_last) begin
                    frame_rdy <= 1'b0;
                    rdptr     <= '0;
                    cnt       <= '0;
                end else begin
                    rdptr <= rdptr + 1'b1;
                end
            end
        end else if (accept) begin
            if (room)    cnt       <= wslot + 1'b1;
            if (is_tail) frame_rdy <= 1'b1;
        end
    end

    p_len_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNTW'(FRAME_MAX));

    p_hold_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_rdy && !rd_pop) |=> (frame_rdy && $stable(cnt)));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_tail) |=> frame_rdy);

endmodule

// File: rtl/noc_credit_ni.sv
// Credit-gated virtual-channel network interface, top level.
// What it does: one credit tracker per channel gates the transmit scheduler.
// One reassembly lane per channel collects incoming flits, and a channel
// select picks which lane the processing element reads.
// Assumes: DOWN_DEPTH >= 2 and NUM_VC >= 2.
module noc_credit_ni
    import noc_ni_pkg::*;
#(
    parameter int NUM_VC     = 2,
    parameter int DOWN_DEPTH = 2,
    parameter int FRAME_MAX  = 512,
    localparam int VCW       = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_VC-1:0]        pe_tx_valid,
    input  logic [NUM_VC*BYTE_W-1:0] pe_tx_byte,
    input  logic [NUM_VC-1:0]        pe_tx_last,
    output logic [NUM_VC-1:0]        pe_tx_ready,
    output logic                     net_out_valid,
    output logic [BYTE_W-1:0]        net_out_data,
    output logic [FT_W-1:0]          net_out_type,
    output logic [VCW-1:0]           net_out_vc,
    input  logic [NUM_VC-1:0]        cr_req,
    output logic [NUM_VC-1:0]        cr_ack,
    input  logic                     net_in_valid,
    input  logic [BYTE_W-1:0]        net_in_data,
    input  logic [FT_W-1:0]          net_in_type,
    input  logic [VCW-1:0]           net_in_vc,
    output logic [NUM_VC-1:0]        rx_frame_rdy,
    input  logic [VCW-1:0]           rx_sel,
    input  logic                     rx_pop,
    output logic [BYTE_W-1:0]        rx_byte,
    output logic                     rx_last
);

    localparam int INIT_TOK = DOWN_DEPTH / 2;
    localparam int TOKW     = $clog2(INIT_TOK + 2);
    localparam int CNTW     = $clog2(FRAME_MAX + 1);
    localparam int PTRW     = $clog2(FRAME_MAX);

    logic [NUM_VC-1:0] has_token;
    logic [NUM_VC-1:0] grant;
    logic [BYTE_W-1:0] lane_byte [NUM_VC];
    logic [NUM_VC-1:0] lane_last;

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        noc_ni_credit_port #(
            .INIT_TOK (INIT_TOK),
            .TOKW     (TOKW)
        ) u_credit (
            .clk       (clk),
            .rst_n     (rst_n),
            .cr_req    (cr_req[v]),
            .spend     (grant[v]),
            .cr_ack    (cr_ack[v]),
            .has_token (has_token[v])
        );

        noc_ni_rx_lane #(
            .FRAME_MAX (FRAME_MAX),
            .CNTW      (CNTW),
            .PTRW      (PTRW)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (net_in_valid && (net_in_vc == VCW'(v))),
            .wr_byte   (net_in_data),
            .wr_type   (net_in_type),
            .rd_pop    (rx_pop && (rx_sel == VCW'(v))),
            .frame_rdy (rx_frame_rdy[v]),
            .rd_byte   (lane_byte[v]),
            .rd_last   (lane_last[v])
        );
    end

    noc_ni_tx_sched #(
        .NUM_VC (NUM_VC),
        .VCW    (VCW)
    ) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .pe_valid  (pe_tx_valid),
        .pe_last   (pe_tx_last),
        .pe_byte   (pe_tx_byte),
        .has_token (has_token),
        .grant     (grant),
        .out_valid (net_out_valid),
        .out_data  (net_out_data),
        .out_type  (net_out_type),
        .out_vc    (net_out_vc)
    );

    assign pe_tx_ready = grant;

    // Readout multiplexer driven by the channel select.
    always_comb begin
        rx_byte = '0;
        rx_last = 1'b0;
        for (int v = 0; v < NUM_VC; v++) begin
            if (rx_sel == VCW'(v)) begin
                rx_byte = lane_byte[v];
                rx_last = lane_last[v];
            end
        end
    end

    p_vc_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
        net_out_valid |-> ((($past(pe_tx_ready) >> net_out_vc) & 1) != 0));

    p_out_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        net_out_valid |-> $past(|(pe_tx_ready & pe_tx_valid)));

endmodule

// File: tb/noc_credit_ni_test.sv
module noc_credit_ni_test;

    localparam int NV   = 2;
    localparam int NF   = 12;
    localparam int MAXL = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n;
    logic       tv0, tv1, tl0, tl1, req0, req1;
    logic [7:0] tb0, tb1;
    logic       net_in_valid;
    logic [7:0] net_in_data;
    logic [2:0] net_in_type;
    logic       net_in_vc;
    logic       rx_sel, rx_pop;

    logic [1:0] pe_tx_ready, cr_ack, rx_frame_rdy;
    logic       net_out_valid, rx_last;
    logic [7:0] net_out_data, rx_byte;
    logic [2:0] net_out_type;
    logic       net_out_vc;

    noc_credit_ni uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pe_tx_valid  ({tv1, tv0}),
        .pe_tx_byte   ({tb1, tb0}),
        .pe_tx_last   ({tl1, tl0}),
        .pe_tx_ready  (pe_tx_ready),
        .net_out_valid(net_out_valid),
        .net_out_data (net_out_data),
        .net_out_type (net_out_type),
        .net_out_vc   (net_out_vc),
        .cr_req       ({req1, req0}),
        .cr_ack       (cr_ack),
        .net_in_valid (net_in_valid),
        .net_in_data  (net_in_data),
        .net_in_type  (net_in_type),
        .net_in_vc    (net_in_vc),
        .rx_frame_rdy (rx_frame_rdy),
        .rx_sel       (rx_sel),
        .rx_pop       (rx_pop),
        .rx_byte      (rx_byte),
        .rx_last      (rx_last)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit wd_fired = 0;

    logic [7:0] tx_f   [NV][NF][MAXL];
    int         tx_len [NV][NF];
    int         tot    [NV];
    int         sent   [NV];
    int         cred_up[NV];
    int         credited[NV];
    int         mon_k  [NV];
    int         mon_i  [NV];
    logic [7:0] rx_exp [NV][520];

    task automatic chk(input string r, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    function automatic int exp_type(input int i, input int len);
        int t;
        t = 0;
        if (i == 0)       t = t | 1;
        if (i == len - 1) t = t | 4;
        if (t == 0)       t = 2;
        return t;
    endfunction

    task automatic set_tx(input int v, input logic val, input logic [7:0] b, input logic l);
        if (v == 0) begin tv0 = val; tb0 = b; tl0 = l; end
        else        begin tv1 = val; tb1 = b; tl1 = l; end
    endtask

    task automatic set_req(input int mask, input logic val);
        if (mask[0]) req0 = val;
        if (mask[1]) req1 = val;
    endtask

    // Raise credit request(s); acknowledge must appear at the third falling edge (R4).
    task automatic credit_up(input int mask);
        int n;
        set_req(mask, 1'b1);
        n = 0;
        while (((int'(cr_ack) & mask) != mask) && n < 10) begin
            @(negedge clk);
            n++;
        end
        chk("R4", "ack rise latency", n, 3);
    endtask

    task automatic credit_down(input int mask);
        int n;
        set_req(mask, 1'b0);
        n = 0;
        while (((int'(cr_ack) & mask) != 0) && n < 10) begin
            @(negedge clk);
            n++;
        end
        chk("R4", "ack fall latency", n, 3);
    endtask

    task automatic send_rx(input int v, input int t, input logic [7:0] b);
        @(negedge clk);
        net_in_valid = 1'b1;
        net_in_vc    = v[0];
        net_in_type  = t[2:0];
        net_in_data  = b;
    endtask

    task automatic end_rx();
        @(negedge clk);
        net_in_valid = 1'b0;
    endtask

    // Pop a frame out of channel v and compare with rx_exp (R10).
    task automatic read_chk(input int v, input int len);
        rx_sel = v[0];
        for (int i = 0; i < len; i++) begin
            #1;
            chk("R10", "rx byte", rx_byte, rx_exp[v][i]);
            chk("R10", "rx last", rx_last, (i == len - 1) ? 1 : 0);
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
        end
        #1;
        chk("R10", "ready cleared after final pop", rx_frame_rdy[v], 0);
    endtask

    task automatic drive_vc(input int v);
        for (int k = 0; k < NF; k++) begin
            for (int i = 0; i < tx_len[v][k]; i++) begin
                int gap;
                gap = $urandom_range(0, 2);
                if (gap > 0) begin
                    set_tx(v, 1'b0, 8'h00, 1'b0);
                    repeat (gap) @(negedge clk);
                end
                set_tx(v, 1'b1, tx_f[v][k][i], (i == tx_len[v][k] - 1));
                #2;
                while (!pe_tx_ready[v]) begin
                    @(negedge clk);
                    #2;
                end
                @(negedge clk);
            end
        end
        set_tx(v, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic respond(input int v);
        while (credited[v] < tot[v]) begin
            wait (sent[v] > credited[v]);
            @(negedge clk);
            repeat ($urandom_range(0, 4)) @(negedge clk);
            credit_up(1 << v);
            cred_up[v]++;
            credit_down(1 << v);
            credited[v]++;
        end
    endtask

    task automatic monitor_tx();
        int seen;
        seen = 0;
        while (seen < tot[0] + tot[1]) begin
            @(negedge clk);
            if (net_out_valid) begin
                int v, k, i;
                v = int'(net_out_vc);
                chk("R3", "token available for sent flit", (1 + cred_up[v] - sent[v]) > 0, 1);
                k = mon_k[v];
                i = mon_i[v];
                if (k >= NF) begin
                    chk("R5", "unexpected flit on channel", v, -1);
                end else begin
                    chk("R6", "random flit data", net_out_data, tx_f[v][k][i]);
                    chk("R6", "random flit type", net_out_type, exp_type(i, tx_len[v][k]));
                    if (i + 1 == tx_len[v][k]) begin mon_k[v] = k + 1; mon_i[v] = 0; end
                    else mon_i[v] = i + 1;
                end
                sent[v]++;
                seen++;
            end
        end
    endtask

    task automatic run_all();
        // ---------------- reset (R1)
        rst_n = 1'b0;
        tv0 = 0; tv1 = 0; tl0 = 0; tl1 = 0; tb0 = 0; tb1 = 0;
        req0 = 0; req1 = 0;
        net_in_valid = 0; net_in_data = 0; net_in_type = 0; net_in_vc = 0;
        rx_sel = 0; rx_pop = 0;
        repeat (3) @(negedge clk);
        chk("R1", "out valid in reset", net_out_valid, 0);
        chk("R1", "ack in reset", cr_ack, 0);
        chk("R1", "rx ready in reset", rx_frame_rdy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out valid after reset", net_out_valid, 0);
        chk("R1", "ack after reset", cr_ack, 0);
        chk("R1", "rx ready after reset", rx_frame_rdy, 0);

        // ---------------- one token, stall, credit (R2 R3 R6 R8)
        set_tx(0, 1'b1, 8'h31, 1'b0);
        #2;
        chk("R2", "initial token offers channel 0", pe_tx_ready, 1);
        chk("R8", "no flit before the edge", net_out_valid, 0);
        @(negedge clk);
        chk("R8", "flit after accept", net_out_valid, 1);
        chk("R5", "vc field", net_out_vc, 0);
        chk("R6", "head type", net_out_type, 1);
        chk("R6", "head data", net_out_data, 'h31);
        set_tx(0, 1'b1, 8'h32, 1'b0);
        #2;
        chk("R2", "only one initial token", pe_tx_ready, 0);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            #2;
            chk("R3", "stalled without token", pe_tx_ready, 0);
            chk("R3", "no flit while stalled", net_out_valid, 0);
        end
        set_tx(0, 1'b0, 8'h32, 1'b0);
        credit_up(1);
        credit_down(1);
        set_tx(0, 1'b1, 8'h32, 1'b0);
        #2;
        chk("R3", "credit resumes channel", pe_tx_ready, 1);
        @(negedge clk);
        chk("R6", "body type", net_out_type, 2);
        chk("R6", "body data", net_out_data, 'h32);
        set_tx(0, 1'b0, 8'h00, 1'b0);
        credit_up(1);
        credit_down(1);
        set_tx(0, 1'b1, 8'h33, 1'b1);
        @(negedge clk);
        chk("R6", "tail type", net_out_type, 4);
        chk("R6", "tail data", net_out_data, 'h33);
        set_tx(0, 1'b0, 8'h00, 1'b0);
        credit_up(1);
        credit_down(1);

        // single-byte frame on channel 1 (R5 R6)
        set_tx(1, 1'b1, 8'h77, 1'b1);
        @(negedge clk);
        chk("R5", "vc field channel 1", net_out_vc, 1);
        chk("R6", "single flit type", net_out_type, 5);
        chk("R6", "single flit data", net_out_data, 'h77);
        set_tx(1, 1'b0, 8'h00, 1'b0);
        credit_up(2);
        credit_down(2);

        // ---------------- round robin (R7)
        set_tx(0, 1'b1, 8'h10, 1'b0);
        set_tx(1, 1'b1, 8'h20, 1'b0);
        #2;
        chk("R7", "channel 0 wins first", pe_tx_ready, 1);
        @(negedge clk);
        chk("R7", "first flit channel", net_out_vc, 0);
        chk("R7", "first flit data", net_out_data, 'h10);
        set_tx(0, 1'b1, 8'h11, 1'b1);
        #2;
        chk("R7", "channel 1 next", pe_tx_ready, 2);
        @(negedge clk);
        chk("R7", "second flit channel", net_out_vc, 1);
        chk("R6", "second flit head", net_out_type, 1);
        set_tx(1, 1'b1, 8'h21, 1'b1);
        #2;
        chk("R3", "both stalled", pe_tx_ready, 0);
        set_tx(0, 1'b0, 8'h11, 1'b1);
        set_tx(1, 1'b0, 8'h21, 1'b1);
        credit_up(3);
        credit_down(3);
        set_tx(0, 1'b1, 8'h11, 1'b1);
        set_tx(1, 1'b1, 8'h21, 1'b1);
        #2;
        chk("R7", "rotation back to channel 0", pe_tx_ready, 1);
        @(negedge clk);
        chk("R7", "third flit data", net_out_data, 'h11);
        chk("R6", "third flit tail", net_out_type, 4);
        set_tx(0, 1'b0, 8'h00, 1'b0);
        #2;
        chk("R7", "channel 1 after channel 0", pe_tx_ready, 2);
        @(negedge clk);
        chk("R7", "fourth flit channel", net_out_vc, 1);
        chk("R7", "fourth flit data", net_out_data, 'h21);
        set_tx(1, 1'b0, 8'h00, 1'b0);
        credit_up(3);
        credit_down(3);

        // ---------------- random transmit with credit responders
        for (int v = 0; v < NV; v++) begin
            tot[v] = 0; sent[v] = 0; cred_up[v] = 0; credited[v] = 0;
            mon_k[v] = 0; mon_i[v] = 0;
            for (int k = 0; k < NF; k++) begin
                tx_len[v][k] = $urandom_range(1, MAXL);
                tot[v] += tx_len[v][k];
                for (int i = 0; i < MAXL; i++) tx_f[v][k][i] = 8'($urandom);
            end
        end
        fork
            drive_vc(0);
            drive_vc(1);
            respond(0);
            respond(1);
            monitor_tx();
        join
        chk("R5", "all channel 0 flits seen", mon_k[0], NF);
        chk("R5", "all channel 1 flits seen", mon_k[1], NF);

        // ---------------- receive: interleaved steering (R9)
        rx_exp[0][0] = 8'hA0; rx_exp[0][1] = 8'hA1;
        rx_exp[1][0] = 8'hB0; rx_exp[1][1] = 8'hB1; rx_exp[1][2] = 8'hB2;
        send_rx(0, 1, 8'hA0);
        send_rx(1, 1, 8'hB0);
        send_rx(0, 4, 8'hA1);
        end_rx();
        chk("R9", "only channel 0 released", rx_frame_rdy, 1);
        send_rx(1, 2, 8'hB1);
        send_rx(1, 4, 8'hB2);
        end_rx();
        chk("R9", "both released", rx_frame_rdy, 3);
        // frame into a full channel is discarded (R11)
        send_rx(1, 1, 8'h55);
        send_rx(1, 4, 8'h66);
        end_rx();
        chk("R11", "full channel stays ready", rx_frame_rdy, 3);
        read_chk(0, 2);
        read_chk(1, 3);

        // oversize frame (R11)
        for (int i = 0; i < 515; i++) begin
            send_rx(0, (i == 0) ? 1 : ((i == 514) ? 4 : 2), 8'(i));
            if (i < 512) rx_exp[0][i] = 8'(i);
        end
        end_rx();
        chk("R11", "oversize frame released", rx_frame_rdy[0], 1);
        read_chk(0, 512);

        // random interleaved receive rounds (R9 R10)
        for (int r = 0; r < 6; r++) begin
            int len[NV];
            int p[NV];
            for (int v = 0; v < NV; v++) begin
                len[v] = $urandom_range(1, 12);
                p[v]   = 0;
                for (int i = 0; i < len[v]; i++) rx_exp[v][i] = 8'($urandom);
            end
            while (p[0] < len[0] || p[1] < len[1]) begin
                int v;
                v = $urandom_range(0, 1);
                if (p[v] >= len[v]) v = 1 - v;
                send_rx(v, exp_type(p[v], len[v]), rx_exp[v][p[v]]);
                p[v]++;
            end
            end_rx();
            chk("R9", "random round both released", rx_frame_rdy, 3);
            read_chk(0, len[0]);
            read_chk(1, len[1]);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd_fired = 1;
            end
        join_any
        disable fork;
        if (wd_fired) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule